// File: doc/BRIEF.md
# Atomic Swap Sequencer

This block performs one read-then-write exchange at a single address, in word or byte size. A requester presents the address, the new data, the access size and the memory attributes of the target region. The block returns the value the location held before the exchange and pulses a completion strobe.

The block uses one of two paths. For a cacheable region it issues an ordinary load and then an ordinary store through the cache port. For a non-cacheable region it first asks the write buffer to empty and waits for it. It then raises a bus lock, performs a single bus read, and performs a bus write. That write always goes straight to the bus and is acknowledged there, whatever the region's bufferable attribute says. The lock is released once the write has been acknowledged. From acceptance to completion the block holds an interrupt-block output, so that nothing can be taken between the two halves. If the cache reports a hit for a non-cacheable exchange, the block marks a programming error but still carries out the bus exchange.

Top module: `atomic_swap_seq`

## Requirements
- R1: After reset the block is idle: `req_ready` is 1, and `done`, `swap_err`, `irq_block`, `bus_lock`, `wb_drain_req` and all four cache/bus request outputs are 0.
- R2: When `req_cacheable` is 1, the block issues one cache read and then one cache write to the captured address. It makes no bus request and keeps `bus_lock` at 0. The cache write carries the request's bufferable attribute on `cache_wr_buf`.
- R3: `irq_block` is 1 in every cycle from the cycle after acceptance up to and including the `done` cycle. It is 0 while the block is idle.
- R4: When `req_cacheable` is 0, `wb_drain_req` is held until `wb_empty` is seen at 1. No bus read is requested before that.
- R5: A non-cacheable exchange makes exactly one bus read and then exactly one bus write, both at the request address and with `bus_byte` equal to the request size. It makes no cache read or write.
- R6: The non-cacheable write is always performed on the bus, whatever the value of `req_bufferable`. `bus_wr_req` stays high until `bus_ack`, and `done` follows only after that acknowledge.
- R7: `bus_lock` rises the cycle before `bus_rd_req` rises. It stays high through both bus phases and is 0 again in the `done` cycle.
- R8: If `req_cacheable` is 0 and `cache_hit` is 1 at acceptance, `swap_err` is 1 in the `done` cycle and the bus exchange still completes. If the region is cacheable, a hit raises no error.
- R9: Byte size (`req_byte`=1): the lane is taken from address bits [1:0], with lane 0 at data bits [7:0]. The read byte is returned zero-extended, and the write data repeats `req_wdata[7:0]` on every lane. Word size returns and writes all 32 bits.
- R10: `rsp_data` holds the value the location had before the exchange in the `done` cycle, and `done` is a one-cycle pulse after which `req_ready` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Exchange request, taken when `req_ready` is 1 |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_addr | input | ADDR_W | Exchange address |
| req_wdata | input | DATA_W | Value to store |
| req_byte | input | 1 | 1 = byte exchange, 0 = word exchange |
| req_cacheable | input | 1 | Region is cacheable |
| req_bufferable | input | 1 | Region is bufferable |
| cache_hit | input | 1 | Cache lookup result for `req_addr` at acceptance |
| done | output | 1 | One-cycle completion pulse |
| rsp_data | output | DATA_W | Value read by the exchange |
| swap_err | output | 1 | Programming error, valid with `done` |
| irq_block | output | 1 | Interrupts held off |
| cache_rd_req | output | 1 | Cache load request |
| cache_wr_req | output | 1 | Cache store request |
| cache_addr | output | ADDR_W | Cache access address |
| cache_wdata | output | DATA_W | Cache store data |
| cache_byte | output | 1 | Cache access size is byte |
| cache_wr_buf | output | 1 | Store may be buffered |
| cache_ack | input | 1 | Cache access complete |
| cache_rdata | input | DATA_W | Cache load data, valid with `cache_ack` |
| wb_drain_req | output | 1 | Request that the write buffer empties |
| wb_empty | input | 1 | Write buffer holds no entries |
| bus_lock | output | 1 | Bus held for an atomic sequence |
| bus_rd_req | output | 1 | Bus read request |
| bus_wr_req | output | 1 | Bus write request |
| bus_addr | output | ADDR_W | Bus address |
| bus_wdata | output | DATA_W | Bus write data |
| bus_byte | output | 1 | Bus access size is byte |
| bus_ack | input | 1 | Bus access complete |
| bus_rdata | input | DATA_W | Bus read data, valid with `bus_ack` |

## Verification
A sequencer stuck in the wrong state shows up at the ports within a cycle. The request outputs are each one-hot to a state, so a bad state gives a bus request without the lock, a cache access during a locked exchange, or a missing or doubled request. A bad captured address, size or lane shows up as a wrong `rsp_data` or a wrong post-exchange memory word in the `done` cycle. A skipped drain or a mistimed lock edge shows up on the first cycle of the bus read. The bench therefore samples every cycle of each exchange, and it checks the read data and the memory image when the exchange completes.

// File: rtl/swap_seq_pkg.sv
package swap_seq_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_CRD   = 3'd1,
      ST_CWR   = 3'd2,
      ST_DRAIN = 3'd3,
      ST_LOCK  = 3'd4,
      ST_BRD   = 3'd5,
      ST_BWR   = 3'd6,
      ST_DONE  = 3'd7
   } swap_st_e;
endpackage

// File: rtl/swap_lane.sv
module swap_lane #(
   parameter int DATA_W   = 32,
   parameter bit BIG_LANE = 1'b0,
   localparam int LANES   = DATA_W / 8,
   localparam int LW      = $clog2(LANES)
) (
   input  logic [LW-1:0]     addr_lo,
   input  logic              is_byte,
   input  logic [DATA_W-1:0] rd_raw,
   input  logic [DATA_W-1:0] wr_in,
   output logic [DATA_W-1:0] rd_out,
   output logic [DATA_W-1:0] wr_out
);
   logic [LW-1:0] lane;
   logic [7:0]    sel_byte;

   generate
      if (DATA_W < 16 || (DATA_W % 8) != 0) begin : g_bad_width
         $error("swap_lane: DATA_W must be a multiple of 8 and at least 16");
      end
      if (BIG_LANE) begin : g_big
         assign lane = LW'(LANES - 1) - addr_lo;
      end else begin : g_little
         assign lane = addr_lo;
      end
   endgenerate

   assign sel_byte = rd_raw[{lane, 3'b000} +: 8];

   always_comb begin
      if (is_byte) begin
         rd_out = {{(DATA_W-8){1'b0}}, sel_byte};
         wr_out = {LANES{wr_in[7:0]}};
      end else begin
         rd_out = rd_raw;
         wr_out = wr_in;
      end
   end
endmodule

// File: rtl/swap_ctrl.sv
module swap_ctrl
   import swap_seq_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     start,
   input  logic     cacheable,
   input  logic     cache_ack,
   input  logic     bus_ack,
   input  logic     wb_empty,
   output swap_st_e state,
   output logic     idle,
   output logic     busy,
   output logic     done,
   output logic     cache_rd,
   output logic     cache_wr,
   output logic     bus_rd,
   output logic     bus_wr,
   output logic     drain,
   output logic     lock
);
   swap_st_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE:  if (start) st_d = cacheable ? ST_CRD : ST_DRAIN;
         ST_CRD:   if (cache_ack) st_d = ST_CWR;
         ST_CWR:   if (cache_ack) st_d = ST_DONE;
         ST_DRAIN: if (wb_empty) st_d = ST_LOCK;
         ST_LOCK:  st_d = ST_BRD;
         ST_BRD:   if (bus_ack) st_d = ST_BWR;
         ST_BWR:   if (bus_ack) st_d = ST_DONE;
         ST_DONE:  st_d = ST_IDLE;
         default:  st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end

   assign state    = st_q;
   assign idle     = (st_q == ST_IDLE);
   assign busy     = (st_q != ST_IDLE);
   assign done     = (st_q == ST_DONE);
   assign cache_rd = (st_q == ST_CRD);
   assign cache_wr = (st_q == ST_CWR);
   assign bus_rd   = (st_q == ST_BRD);
   assign bus_wr   = (st_q == ST_BWR);
   assign drain    = (st_q == ST_DRAIN);
   assign lock     = (st_q == ST_LOCK) || (st_q == ST_BRD) || (st_q == ST_BWR);

   p_lock_on_bus_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd || bus_wr) |-> lock);
   p_lock_early_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_rd) |-> $past(lock));
   p_done_unlocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !lock);
   p_drained_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_rd) |-> $past(wb_empty, 2));
   p_cache_unlocked_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cache_rd || cache_wr) |-> !lock);
   p_irq_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cache_rd || cache_wr || bus_rd || bus_wr || drain || done) |-> busy);
   p_one_request_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cache_rd, cache_wr, bus_rd, bus_wr, drain}));
   p_write_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !bus_ack) |=> bus_wr);
   p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

// File: rtl/atomic_swap_seq.sv
module atomic_swap_seq
   import swap_seq_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int DATA_W   = 32,
   parameter bit BIG_LANE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              req_byte,
   input  logic              req_cacheable,
   input  logic              req_bufferable,
   input  logic              cache_hit,
   output logic              done,
   output logic [DATA_W-1:0] rsp_data,
   output logic              swap_err,
   output logic              irq_block,
   output logic              cache_rd_req,
   output logic              cache_wr_req,
   output logic [ADDR_W-1:0] cache_addr,
   output logic [DATA_W-1:0] cache_wdata,
   output logic              cache_byte,
   output logic              cache_wr_buf,
   input  logic              cache_ack,
   input  logic [DATA_W-1:0] cache_rdata,
   output logic              wb_drain_req,
   input  logic              wb_empty,
   output logic              bus_lock,
   output logic              bus_rd_req,
   output logic              bus_wr_req,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   output logic              bus_byte,
   input  logic              bus_ack,
   input  logic [DATA_W-1:0] bus_rdata
);
   localparam int LW = $clog2(DATA_W / 8);

   generate
      if (ADDR_W <= LW) begin : g_bad_addr
         $error("atomic_swap_seq: ADDR_W must exceed the lane index width");
      end
   endgenerate

   swap_st_e          state;
   logic              idle, start;
   logic              c_rd, c_wr, b_rd, b_wr;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q, rdata_q, rd_sel, rd_ext, wr_lane;
   logic              byte_q, buf_q, err_q;

   assign start = req_valid && idle;

   swap_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .cacheable (req_cacheable),
      .cache_ack (cache_ack),
      .bus_ack   (bus_ack),
      .wb_empty  (wb_empty),
      .state     (state),
      .idle      (idle),
      .busy      (irq_block),
      .done      (done),
      .cache_rd  (c_rd),
      .cache_wr  (c_wr),
      .bus_rd    (b_rd),
      .bus_wr    (b_wr),
      .drain     (wb_drain_req),
      .lock      (bus_lock)
   );

   assign rd_sel = (state == ST_CRD) ? cache_rdata : bus_rdata;

   swap_lane #(.DATA_W(DATA_W), .BIG_LANE(BIG_LANE)) u_lane (
      .addr_lo (addr_q[LW-1:0]),
      .is_byte (byte_q),
      .rd_raw  (rd_sel),
      .wr_in   (wdata_q),
      .rd_out  (rd_ext),
      .wr_out  (wr_lane)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
         byte_q  <= 1'b0;
         buf_q   <= 1'b0;
         err_q   <= 1'b0;
      end else if (start) begin
         addr_q  <= req_addr;
         wdata_q <= req_wdata;
         byte_q  <= req_byte;
         buf_q   <= req_bufferable;
         err_q   <= !req_cacheable && cache_hit;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          rdata_q <= '0;
      else if ((c_rd && cache_ack) || (b_rd && bus_ack)) rdata_q <= rd_ext;
   end

   assign req_ready    = idle;
   assign rsp_data     = rdata_q;
   assign swap_err     = done && err_q;

   assign cache_rd_req = c_rd;
   assign cache_wr_req = c_wr;
   assign cache_addr   = addr_q;
   assign cache_wdata  = wr_lane;
   assign cache_byte   = byte_q;
   assign cache_wr_buf = buf_q;

   assign bus_rd_req   = b_rd;
   assign bus_wr_req   = b_wr;
   assign bus_addr     = addr_q;
   assign bus_wdata    = wr_lane;
   assign bus_byte     = byte_q;

   p_no_bus_cached_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cache_rd_req || cache_wr_req) |-> !(bus_rd_req || bus_wr_req || bus_lock));
   p_err_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      swap_err |-> done);
   p_addr_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr_req && $past(bus_rd_req)) |-> $stable(bus_addr));
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !(irq_block || bus_lock || wb_drain_req));
endmodule

// File: tb/tb_atomic_swap_seq.sv
module tb_atomic_swap_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_ready;
   logic [31:0] req_addr = '0, req_wdata = '0;
   logic        req_byte = 1'b0, req_cacheable = 1'b0, req_bufferable = 1'b0, cache_hit = 1'b0;
   logic        done, swap_err, irq_block;
   logic [31:0] rsp_data;
   logic        cache_rd_req, cache_wr_req, cache_byte, cache_wr_buf;
   logic [31:0] cache_addr, cache_wdata;
   logic        cache_ack = 1'b0;
   logic [31:0] cache_rdata = '0;
   logic        wb_drain_req, wb_empty;
   logic        bus_lock, bus_rd_req, bus_wr_req, bus_byte;
   logic [31:0] bus_addr, bus_wdata;
   logic        bus_ack = 1'b0;
   logic [31:0] bus_rdata = '0;

   int checks = 0, errors = 0, cyc = 0, wb_pend = 0;
   logic [31:0] bmem [16];
   logic [31:0] cmem [16];
   int bwait = 0, cwait = 0;

   always #4 clk = ~clk;

   atomic_swap_seq dut (.*);

   assign wb_empty = (wb_pend == 0);

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
         end
      end
   end

   // write buffer model: empties one entry per cycle while drain is requested
   initial forever begin
      @(negedge clk);
      if (wb_drain_req && wb_pend > 0) wb_pend--;
   end

   // bus responder
   initial forever begin
      @(negedge clk);
      if (bus_ack) bus_ack = 1'b0;
      else if (bus_rd_req || bus_wr_req) begin
         if (bwait == 0) begin
            bus_ack = 1'b1;
            if (bus_rd_req) bus_rdata = bmem[bus_addr[5:2]];
            else if (bus_byte)
               bmem[bus_addr[5:2]][{bus_addr[1:0], 3'b000} +: 8] = bus_wdata[{bus_addr[1:0], 3'b000} +: 8];
            else bmem[bus_addr[5:2]] = bus_wdata;
            bwait = $urandom_range(0, 3);
         end else bwait--;
      end
   end

   // cache responder
   initial forever begin
      @(negedge clk);
      if (cache_ack) cache_ack = 1'b0;
      else if (cache_rd_req || cache_wr_req) begin
         if (cwait == 0) begin
            cache_ack = 1'b1;
            if (cache_rd_req) cache_rdata = cmem[cache_addr[5:2]];
            else if (cache_byte)
               cmem[cache_addr[5:2]][{cache_addr[1:0], 3'b000} +: 8] = cache_wdata[{cache_addr[1:0], 3'b000} +: 8];
            else cmem[cache_addr[5:2]] = cache_wdata;
            cwait = $urandom_range(0, 2);
         end else cwait--;
      end
   end

   function automatic logic [31:0] exp_read(input logic [31:0] old, input logic [1:0] lo, input bit byt);
      return byt ? {24'h0, old[{lo, 3'b000} +: 8]} : old;
   endfunction

   function automatic logic [31:0] exp_write(input logic [31:0] old, input logic [1:0] lo, input bit byt,
                                             input logic [31:0] wd);
      logic [31:0] r;
      r = old;
      if (byt) r[{lo, 3'b000} +: 8] = wd[7:0];
      else     r = wd;
      return r;
   endfunction

   task automatic swap(input logic [31:0] addr, input logic [31:0] wd, input bit byt, input bit cach,
                       input bit bufa, input bit hit, input int pend);
      logic [31:0] old, exp_rd, exp_new, other_before;
      int n_brd = 0, n_bwr = 0, n_crd = 0, n_cwr = 0, t = 0;
      bit prev_rd = 0, prev_lock = 0, lock_bad = 0, drain_bad = 0, irq_bad = 0, early_bad = 0, size_bad = 0;
      bit seen_done = 0;
      int idx = int'(addr[5:2]);
      old = cach ? cmem[idx] : bmem[idx];
      other_before = cach ? bmem[idx] : cmem[idx];
      exp_rd  = exp_read(old, addr[1:0], byt);
      exp_new = exp_write(old, addr[1:0], byt, wd);
      @(negedge clk);
      wb_pend = pend;
      req_valid = 1'b1; req_addr = addr; req_wdata = wd; req_byte = byt;
      req_cacheable = cach; req_bufferable = bufa; cache_hit = hit;
      @(negedge clk);
      req_valid = 1'b0; cache_hit = 1'b0;
      while (!seen_done && t < 200) begin
         #1;
         if (!irq_block) irq_bad = 1;
         if (bus_rd_req && !prev_rd) begin
            n_brd++;
            if (!prev_lock) early_bad = 1;
            if (wb_pend != 0) drain_bad = 1;
         end
         if (bus_wr_req && bus_ack) n_bwr++;
         if (cache_rd_req && cache_ack) n_crd++;
         if (cache_wr_req && cache_ack) n_cwr++;
         if ((bus_rd_req || bus_wr_req) && (!bus_lock || bus_addr != addr || bus_byte != byt)) lock_bad = 1;
         if (cach && bus_lock) lock_bad = 1;
         if ((cache_rd_req || cache_wr_req) && (cache_addr != addr || cache_byte != byt)) size_bad = 1;
         if (cache_wr_req && cache_wr_buf != bufa) size_bad = 1;
         if (done) begin
            seen_done = 1;
            chk(rsp_data == exp_rd, "R10 R9 read data", rsp_data, exp_rd);
            chk(swap_err == (!cach && hit), "R8 error flag", {31'h0, swap_err}, {31'h0, !cach && hit});
            chk(!bus_lock, "R7 lock released at done", {31'h0, bus_lock}, 32'h0);
            chk((cach ? cmem[idx] : bmem[idx]) == exp_new, "R9 R6 written value",
                cach ? cmem[idx] : bmem[idx], exp_new);
            chk((cach ? bmem[idx] : cmem[idx]) == other_before, "R2 R5 other path untouched",
                cach ? bmem[idx] : cmem[idx], other_before);
         end else begin
            prev_rd = bus_rd_req; prev_lock = bus_lock;
            @(negedge clk);
            t++;
         end
      end
      chk(seen_done, "R10 exchange completes", {31'h0, seen_done}, 32'h1);
      chk(!irq_bad, "R3 irq_block held", {31'h0, irq_bad}, 32'h0);
      if (cach) begin
         chk(n_crd == 1 && n_cwr == 1 && n_brd == 0, "R2 one cache load and store", n_crd * 16 + n_cwr, 32'h11);
         chk(!lock_bad && !size_bad, "R2 no lock, attributes", {30'h0, lock_bad, size_bad}, 32'h0);
      end else begin
         chk(n_brd == 1 && n_bwr == 1 && n_crd == 0 && n_cwr == 0, "R5 R6 one bus read and write",
             n_brd * 16 + n_bwr, 32'h11);
         chk(!drain_bad, "R4 drained before read", {31'h0, drain_bad}, 32'h0);
         chk(!early_bad && !lock_bad, "R7 lock timing", {30'h0, early_bad, lock_bad}, 32'h0);
      end
      @(negedge clk); #1;
      chk(req_ready && !done && !irq_block, "R10 back to idle", {29'h0, req_ready, done, irq_block}, 32'h4);
   endtask

   initial begin
      void'($urandom(32'd20251));
      for (int i = 0; i < 16; i++) begin
         bmem[i] = $urandom;
         cmem[i] = $urandom;
      end
      repeat (3) @(negedge clk);
      #1;
      chk(req_ready && !done && !swap_err && !irq_block && !bus_lock && !wb_drain_req &&
          !bus_rd_req && !bus_wr_req && !cache_rd_req && !cache_wr_req, "R1 reset state",
          {22'h0, req_ready, done, swap_err, irq_block, bus_lock, wb_drain_req,
           bus_rd_req, bus_wr_req, cache_rd_req, cache_wr_req}, 32'h200);
      rst_n = 1'b1;
      // directed: byte on every lane, both paths
      for (int l = 0; l < 4; l++) begin
         swap({26'h0, 4'd3, l[1:0]}, 32'hA5A5_5A00 | l, 1'b1, 1'b0, 1'b0, 1'b0, 2);
         swap({26'h0, 4'd5, l[1:0]}, 32'h1234_56C0 | l, 1'b1, 1'b1, 1'b0, 1'b0, 0);
      end
      // R6: bufferable non-cacheable write still goes to the bus
      swap(32'h0000_0020, 32'hDEAD_BEEF, 1'b0, 1'b0, 1'b1, 1'b0, 5);
      // R8: hit on non-cacheable flags error, hit on cacheable does not
      swap(32'h0000_0024, 32'hCAFE_F00D, 1'b0, 1'b0, 1'b0, 1'b1, 0);
      swap(32'h0000_0028, 32'h0BAD_CAFE, 1'b0, 1'b1, 1'b1, 1'b1, 0);
      // R4: long drain
      swap(32'h0000_003C, 32'h7777_1111, 1'b0, 1'b0, 1'b0, 1'b0, 9);
      // constrained random mix
      for (int k = 0; k < 60; k++) begin
         logic [31:0] a;
         a = {26'h0, 6'($urandom_range(0, 63))};
         if ($urandom_range(0, 1) == 0) a[1:0] = 2'b00;
         swap(a, $urandom, a[1:0] != 2'b00 ? 1'b1 : 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
              1'($urandom_range(0, 1)), ($urandom_range(0, 3) == 0), $urandom_range(0, 4));
      end
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule